// File: doc/BRIEF.md
# Voltage and Frequency Step Sequencer

This controller moves a processor core between discrete performance levels. A level change is requested from outside, usually by software that has detected a change in processor load. The block itself does no load estimation. Each level stands for one supply-voltage code and one clock-frequency code. The sequencer drives both codes toward the new pair in an order that keeps the core safe at every step. On a speed-up the supply is raised and allowed to settle before the clock is sped up. On a slow-down the clock is slowed first, and the supply is lowered only after the clock generator has locked at the new rate.

The core is held in a stall only while the clock generator relocks, so voltage ramps cost no execution time. A request that arrives in the middle of a sequence is held in a one-entry latch; a newer request overwrites an older one. The held request is acted on once the sequencer is back in its idle state. Both waits are guarded by a timer. If the regulator or the clock generator never answers, the block enters a sticky fault state. In that state it holds its codes, releases the stall and ignores further requests until reset.

The states are:
- `ST_IDLE`: holding the current level.
- `ST_UP_VOLT`: supply raised, waiting for settle.
- `ST_UP_LOCK`: clock raised, waiting for lock, core stalled.
- `ST_DN_LOCK`: clock lowered, waiting for lock, core stalled.
- `ST_DN_VOLT`: supply lowered, waiting for settle.
- `ST_FAULT`: a wait timed out.

The transitions are:
- `ST_IDLE`→`ST_UP_VOLT` when the request is above the current level.
- `ST_IDLE`→`ST_DN_LOCK` when the request is below it.
- `ST_UP_VOLT`→`ST_UP_LOCK` on settle.
- `ST_UP_LOCK`→`ST_IDLE` on lock.
- `ST_DN_LOCK`→`ST_DN_VOLT` on lock.
- `ST_DN_VOLT`→`ST_IDLE` on settle.
- Any wait state→`ST_FAULT` on timeout.

Top module: `dvfs_seq`

## Requirements
- R1: After reset the block is at level 0. Both codes are 0, `core_stall`, `pll_relock` and `timeout_err` are low, and a reset also clears a fault.
- R2: A level L maps to voltage code floor(L*31/(NUM_LEVELS-1)) and frequency code floor(L*15/(NUM_LEVELS-1)), with NUM_LEVELS = 12 by default. A requested level at or above NUM_LEVELS is clamped to NUM_LEVELS-1.
- R3: On a request above the current level, `vdd_code` changes first. `freq_code` is raised only after `vdd_settled` has been seen high, from the second cycle of the wait onward.
- R4: On a request below the current level, `freq_code` changes first. `vdd_code` is lowered only after `pll_locked` has been seen high, from the second cycle of the wait onward.
- R5: `core_stall` is high only while waiting for lock after a frequency change, and `vdd_code` never changes while it is high. `pll_relock` is a one-cycle pulse in the cycle that `freq_code` changes.
- R6: A request equal to the current level (after clamping) changes no code and raises no stall.
- R7: A request that arrives while a sequence is running, including in its completing cycle, is latched and a later one replaces it. The latched request is serviced once the block is back in `ST_IDLE`.
- R8: If a settle or lock wait lasts TMO_CYC cycles (default 64), `timeout_err` rises and stays high. Both codes freeze, `core_stall` drops and requests are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe of a new level request |
| req_level | input | 4 | Requested performance level |
| vdd_settled | input | 1 | Regulator reports the supply stable |
| pll_locked | input | 1 | Clock generator reports lock |
| vdd_code | output | 5 | Supply-voltage level code |
| freq_code | output | 4 | Clock-frequency level code |
| pll_relock | output | 1 | One-cycle pulse asking the clock generator to relock |
| core_stall | output | 1 | Holds the core while the clock relocks |
| timeout_err | output | 1 | Sticky flag: a settle or lock wait timed out |

## Verification
The completion of a running sequence and the arrival of a new request can fall in the same clock cycle. The bench provokes this by watching, at the falling edge, for the last stalled cycle of a speed-up: stall high, lock high, no relock pulse. It strobes a lower request in exactly that cycle. The bench judges the outcome correct when the speed-up is seen to finish with the old target's codes and the stall released. The latched request must then start a slow-down on the following cycle and end at the new level.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UP_VOLT,
        ST_UP_LOCK,
        ST_DN_LOCK,
        ST_DN_VOLT,
        ST_FAULT
    } seq_state_t;

    // Linear spread of a level index over the full code range.
    function automatic int unsigned lvl_to_code(input int unsigned lvl,
                                                input int unsigned top_lvl,
                                                input int unsigned max_code);
        return (lvl * max_code) / top_lvl;
    endfunction

endpackage

// File: rtl/dvfs_level_map.sv
module dvfs_level_map
    import dvfs_pkg::*;
#(
    parameter int NUM_LEVELS = 12,
    parameter int LVL_W      = 4,
    parameter int VCODE_W    = 5,
    parameter int FCODE_W    = 4
) (
    input  logic [LVL_W-1:0]   lvl,
    output logic [VCODE_W-1:0] vcode,
    output logic [FCODE_W-1:0] fcode
);

    localparam int TOP_LVL = NUM_LEVELS - 1;
    localparam int VMAX    = (1 << VCODE_W) - 1;
    localparam int FMAX    = (1 << FCODE_W) - 1;

    logic [VCODE_W-1:0] vtab [NUM_LEVELS];
    logic [FCODE_W-1:0] ftab [NUM_LEVELS];

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_row
        assign vtab[g] = VCODE_W'(lvl_to_code(g, TOP_LVL, VMAX));
        assign ftab[g] = FCODE_W'(lvl_to_code(g, TOP_LVL, FMAX));
    end

    assign vcode = vtab[lvl];
    assign fcode = ftab[lvl];

endmodule

// File: rtl/dvfs_wait_timer.sv
module dvfs_wait_timer #(
    parameter int TMO_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic first,
    output logic expired
);

    localparam int                CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign first   = (cnt == '0);
    assign expired = run && (cnt == LAST);

endmodule

// File: rtl/dvfs_req_latch.sv
module dvfs_req_latch #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [LVL_W-1:0] in_lvl,
    input  logic             consume,
    output logic             pend_vld,
    output logic [LVL_W-1:0] pend_lvl
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_lvl <= '0;
        end else if (capture) begin
            pend_vld <= 1'b1;
            pend_lvl <= in_lvl;
        end else if (consume) begin
            pend_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int NUM_LEVELS = 12,
    parameter int REQ_W      = 4,
    parameter int VCODE_W    = 5,
    parameter int FCODE_W    = 4,
    parameter int TMO_CYC    = 64,
    parameter int RESET_LVL  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [REQ_W-1:0]   req_level,
    input  logic               vdd_settled,
    input  logic               pll_locked,
    output logic [VCODE_W-1:0] vdd_code,
    output logic [FCODE_W-1:0] freq_code,
    output logic               pll_relock,
    output logic               core_stall,
    output logic               timeout_err
);

    localparam int                 LVL_W   = $clog2(NUM_LEVELS);
    localparam int                 TOP_LVL = NUM_LEVELS - 1;
    localparam int                 VMAX    = (1 << VCODE_W) - 1;
    localparam int                 FMAX    = (1 << FCODE_W) - 1;
    localparam logic [REQ_W-1:0]   TOP_RAW = REQ_W'(TOP_LVL);
    localparam logic [LVL_W-1:0]   RST_L   = LVL_W'(RESET_LVL);
    localparam logic [VCODE_W-1:0] RST_V   = VCODE_W'(lvl_to_code(RESET_LVL, TOP_LVL, VMAX));
    localparam logic [FCODE_W-1:0] RST_F   = FCODE_W'(lvl_to_code(RESET_LVL, TOP_LVL, FMAX));

    seq_state_t state, state_n;

    logic [LVL_W-1:0]   cur_lvl, tgt_lvl;
    logic [VCODE_W-1:0] tgt_v, vdd_q;
    logic [FCODE_W-1:0] tgt_f, frq_q;

    logic [LVL_W-1:0]   req_clamped;
    logic               pend_vld;
    logic [LVL_W-1:0]   pend_lvl;
    logic               sel_vld;
    logic [LVL_W-1:0]   sel_lvl;
    logic [VCODE_W-1:0] map_v;
    logic [FCODE_W-1:0] map_f;
    logic               go_up, go_dn;
    logic               waiting, wait_first, wait_expired;

    // Clamp incoming request into the valid level range
    assign req_clamped = LVL_W'((req_level > TOP_RAW) ? TOP_RAW : req_level);

    assign waiting = (state == ST_UP_VOLT) || (state == ST_UP_LOCK) ||
                     (state == ST_DN_LOCK) || (state == ST_DN_VOLT);

    dvfs_req_latch #(.LVL_W(LVL_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (req_valid && waiting),
        .in_lvl   (req_clamped),
        .consume  (state == ST_IDLE),
        .pend_vld (pend_vld),
        .pend_lvl (pend_lvl)
    );

    // A fresh strobe outranks an older latched request
    assign sel_vld = req_valid || pend_vld;
    assign sel_lvl = req_valid ? req_clamped : pend_lvl;

    dvfs_level_map #(
        .NUM_LEVELS (NUM_LEVELS),
        .LVL_W      (LVL_W),
        .VCODE_W    (VCODE_W),
        .FCODE_W    (FCODE_W)
    ) u_map (
        .lvl   (sel_lvl),
        .vcode (map_v),
        .fcode (map_f)
    );

    dvfs_wait_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_n != state),
        .run     (waiting),
        .first   (wait_first),
        .expired (wait_expired)
    );

    assign go_up = (state == ST_IDLE) && sel_vld && (sel_lvl > cur_lvl);
    assign go_dn = (state == ST_IDLE) && sel_vld && (sel_lvl < cur_lvl);

    // Next-state logic; an indication in the expiry cycle still wins
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (go_up)      state_n = ST_UP_VOLT;
                else if (go_dn) state_n = ST_DN_LOCK;
            end
            ST_UP_VOLT: begin
                if (vdd_settled && !wait_first) state_n = ST_UP_LOCK;
                else if (wait_expired)          state_n = ST_FAULT;
            end
            ST_UP_LOCK: begin
                if (pll_locked && !wait_first)  state_n = ST_IDLE;
                else if (wait_expired)          state_n = ST_FAULT;
            end
            ST_DN_LOCK: begin
                if (pll_locked && !wait_first)  state_n = ST_DN_VOLT;
                else if (wait_expired)          state_n = ST_FAULT;
            end
            ST_DN_VOLT: begin
                if (vdd_settled && !wait_first) state_n = ST_IDLE;
                else if (wait_expired)          state_n = ST_FAULT;
            end
            ST_FAULT: state_n = ST_FAULT;
            default:  state_n = ST_FAULT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Level bookkeeping and code registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_lvl <= RST_L;
            tgt_lvl <= RST_L;
            tgt_v   <= RST_V;
            tgt_f   <= RST_F;
            vdd_q   <= RST_V;
            frq_q   <= RST_F;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go_up || go_dn) begin
                        tgt_lvl <= sel_lvl;
                        tgt_v   <= map_v;
                        tgt_f   <= map_f;
                    end
                    if (go_up) vdd_q <= map_v;
                    if (go_dn) frq_q <= map_f;
                end
                ST_UP_VOLT: begin
                    if (state_n == ST_UP_LOCK) frq_q <= tgt_f;
                end
                ST_UP_LOCK: begin
                    if (state_n == ST_IDLE) cur_lvl <= tgt_lvl;
                end
                ST_DN_LOCK: begin
                    if (state_n == ST_DN_VOLT) vdd_q <= tgt_v;
                end
                ST_DN_VOLT: begin
                    if (state_n == ST_IDLE) cur_lvl <= tgt_lvl;
                end
                ST_FAULT: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        vdd_code    = vdd_q;
        freq_code   = frq_q;
        core_stall  = (state == ST_UP_LOCK) || (state == ST_DN_LOCK);
        pll_relock  = core_stall && wait_first;
        timeout_err = (state == ST_FAULT);
    end

endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
    parameter int VCODE_W = 5,
    parameter int FCODE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vdd_settled,
    input logic               pll_locked,
    input logic [VCODE_W-1:0] vdd_code,
    input logic [FCODE_W-1:0] freq_code,
    input logic               pll_relock,
    input logic               core_stall,
    input logic               timeout_err
);

    // R3
    fup_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code > $past(freq_code)) |-> $past(vdd_settled));

    // R4
    vdn_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vdd_code < $past(vdd_code)) |-> $past(pll_locked));

    // R5
    stall_vdd_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> $stable(vdd_code));

    // R5
    fchange_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code != $past(freq_code)) |-> pll_relock);

    // R5
    relock_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_relock |-> core_stall);

    // R8
    fault_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> (timeout_err && $stable(vdd_code) &&
                         $stable(freq_code) && !core_stall));

endmodule

bind dvfs_seq dvfs_seq_chk #(.VCODE_W(VCODE_W), .FCODE_W(FCODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vdd_settled (vdd_settled),
    .pll_locked  (pll_locked),
    .vdd_code    (vdd_code),
    .freq_code   (freq_code),
    .pll_relock  (pll_relock),
    .core_stall  (core_stall),
    .timeout_err (timeout_err)
);

// File: tb/tb_dvfs_seq.sv
module tb_dvfs_seq;

    localparam int CLK_PERIOD = 10;
    localparam int SET_LAT    = 5;
    localparam int LOCK_LAT   = 6;
    localparam int NVEC       = 10;
    // {requested level, expected resulting level}
    localparam int VEC [NVEC][2] = '{'{5, 5}, '{11, 11}, '{2, 2}, '{2, 2}, '{15, 11},
                                     '{13, 11}, '{0, 0}, '{7, 7}, '{3, 3}, '{9, 9}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_level = '0;
    logic       vdd_settled, pll_locked;
    logic [4:0] vdd_code;
    logic [3:0] freq_code;
    logic       pll_relock, core_stall, timeout_err;

    int checks = 0;
    int errors = 0;

    dvfs_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .vdd_settled(vdd_settled), .pll_locked(pll_locked),
        .vdd_code(vdd_code), .freq_code(freq_code), .pll_relock(pll_relock),
        .core_stall(core_stall), .timeout_err(timeout_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Regulator and clock-generator models
    logic vdd_dead = 1'b0, pll_dead = 1'b0;
    logic [4:0] v_prev;
    int v_cnt, p_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            vdd_settled <= 1'b1; v_prev <= vdd_code; v_cnt <= 0;
        end else begin
            v_prev <= vdd_code;
            if (vdd_code != v_prev) begin
                vdd_settled <= 1'b0; v_cnt <= SET_LAT;
            end else if (v_cnt > 0) begin
                v_cnt <= v_cnt - 1;
                if (v_cnt == 1 && !vdd_dead) vdd_settled <= 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            pll_locked <= 1'b1; p_cnt <= 0;
        end else if (pll_relock) begin
            pll_locked <= 1'b0; p_cnt <= LOCK_LAT;
        end else if (p_cnt > 0) begin
            p_cnt <= p_cnt - 1;
            if (p_cnt == 1 && !pll_dead) pll_locked <= 1'b1;
        end
    end

    // Ordering and stall monitor
    int first_ev = 0;       // 0 none, 1 voltage first, 2 frequency first, 3 same cycle
    int stall_cyc = 0;
    int vviol = 0;
    logic [4:0] m_v = '0;
    logic [3:0] m_f = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (first_ev == 0) begin
                if (vdd_code != m_v && freq_code != m_f) first_ev = 3;
                else if (vdd_code != m_v)                first_ev = 1;
                else if (freq_code != m_f)               first_ev = 2;
            end
            if (core_stall) stall_cyc++;
            if (core_stall && vdd_code != m_v) vviol++;
        end
        m_v = vdd_code;
        m_f = freq_code;
    end

    function automatic int ev(input int l); return (l * 31) / 11; endfunction
    function automatic int ef(input int l); return (l * 15) / 11; endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input int lvl);
        @(negedge clk);
        req_valid = 1'b1;
        req_level = 4'(lvl);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk_level(input int l, input string req);
        chk(vdd_code == 5'(ev(l)), req, vdd_code, ev(l));
        chk(freq_code == 4'(ef(l)), req, freq_code, ef(l));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cur;
        do_reset();

        // R1 reset state
        chk_level(0, "R1");
        chk(!core_stall && !pll_relock, "R1", core_stall, 0);
        chk(!timeout_err, "R1", timeout_err, 0);

        // Vector walk: R2 mapping and clamp, R3/R4 order, R5 stall, R6 no-op
        cur = 0;
        for (int i = 0; i < NVEC; i++) begin
            int tgt;
            tgt = VEC[i][1];
            first_ev = 0; stall_cyc = 0; vviol = 0;
            send(VEC[i][0]);
            repeat (40) @(negedge clk);
            chk_level(tgt, "R2");
            if (tgt > cur)      chk(first_ev == 1, "R3", first_ev, 1);
            else if (tgt < cur) chk(first_ev == 2, "R4", first_ev, 2);
            else begin
                chk(first_ev == 0, "R6", first_ev, 0);
                chk(stall_cyc == 0, "R6", stall_cyc, 0);
            end
            if (tgt != cur) begin
                chk(stall_cyc > 0, "R5", stall_cyc, 1);
                chk(vviol == 0, "R5", vviol, 0);
            end
            cur = tgt;
        end

        // R7 requests during a transition: latest wins
        send(2);
        repeat (3) @(negedge clk);
        send(6);
        repeat (2) @(negedge clk);
        send(4);
        repeat (100) @(negedge clk);
        chk_level(4, "R7");

        // R7 request in the very cycle a speed-up completes
        send(10);
        begin
            int n;
            n = 0;
            while (!(core_stall && pll_locked && !pll_relock) && n < 100) begin
                @(negedge clk);
                n++;
            end
            chk(n < 100, "R7", n, 0);
        end
        req_valid = 1'b1;
        req_level = 4'd1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!core_stall, "R7", core_stall, 0);
        chk_level(10, "R7");
        repeat (60) @(negedge clk);
        chk_level(1, "R7");

        // R8 settle never arrives
        do_reset();
        vdd_dead = 1'b1;
        send(6);
        repeat (120) @(negedge clk);
        chk(timeout_err, "R8", timeout_err, 1);
        chk(vdd_code == 5'(ev(6)), "R8", vdd_code, ev(6));
        chk(freq_code == 4'(ef(0)), "R8", freq_code, ef(0));
        chk(!core_stall, "R8", core_stall, 0);
        send(3);
        repeat (40) @(negedge clk);
        chk(vdd_code == 5'(ev(6)) && freq_code == 4'(ef(0)), "R8", vdd_code, ev(6));
        chk(timeout_err, "R8", timeout_err, 1);

        // R1 reset clears the fault
        vdd_dead = 1'b0;
        do_reset();
        chk(!timeout_err, "R1", timeout_err, 0);
        chk_level(0, "R1");

        // R8 lock never arrives
        pll_dead = 1'b1;
        send(6);
        repeat (120) @(negedge clk);
        chk(timeout_err, "R8", timeout_err, 1);
        chk_level(6, "R8");
        chk(!core_stall, "R8", core_stall, 0);
        pll_dead = 1'b0;
        do_reset();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule